// File: doc/BRIEF.md
# Clock-Sampled Static RAM Emulator

This block stands in for a small asynchronous static RAM with split data-in and data-out pins inside an FPGA, so that a memory controller can be exercised against it. On every rising clock edge it samples the address, two active-low selects, an active-low write strobe, an active-low output gate and the input word. One cycle later it presents the resulting data word together with a drive flag that replaces a three-state pad. When the drive flag is low the data word is zero. A status flag reports the automatic low-power condition the emulated RAM enters while it is not selected.

A parameter picks one of two output behaviours. With `TRANSPARENT = 0` (split-output variant) the output gate is honoured, and the output floats whenever the write strobe is low. With `TRANSPARENT = 1` (pass-through variant) the output gate is not used, and during a write the word being stored is echoed on the output. The word count is `2**ADDR_W` and the word width is `DATA_W`. The full-size device is `ADDR_W = 14`, `DATA_W = 4`, giving 16384 words of 4 bits. The default build uses `ADDR_W = 11` to keep the array small.

A small state machine records what the last sampled edge asked for.
- `ST_SLEEP` means deselected and powered down. It is also the state held in reset.
- `ST_QUIET` means selected with the output gated off. It is reachable only in the split-output variant.
- `ST_READ` means selected and reading.
- `ST_WRITE` means selected and writing.

Every state can move to every other state, chosen on each edge from the sampled pins:
- either select high moves to `ST_SLEEP`;
- both selects low with the write strobe low moves to `ST_WRITE`;
- both selects low with the write strobe high moves to `ST_READ`, when the output gate is low or the variant is pass-through;
- otherwise the machine moves to `ST_QUIET`.

Top module: `sram_emu`

## Requirements
- R1: The array holds `2**ADDR_W` words of `DATA_W` bits. Each word is selected by the `addr` input, and every word keeps its own value independently of all the others.
- R2: At a rising edge where `ce1_n`, `ce2_n` and `we_n` are all 0, the value on `din` is stored at `addr`.
- R3: At a rising edge where both selects are 0 and `we_n` is 1, the word stored at `addr` appears on `dout` after that edge, with `dout_en` = 1. In the split-output variant this also requires `oe_n` = 0.
- R4: After an edge where `ce1_n` or `ce2_n` is 1, `dout_en` is 0. This includes an edge where a select and `we_n` rise together at the end of a write.
- R5: In the split-output variant (`TRANSPARENT` = 0), after an edge where `we_n` is 0, `dout_en` is 0.
- R6: In the pass-through variant (`TRANSPARENT` = 1), after a write edge, `dout_en` is 1 and `dout` equals the `din` value sampled at that edge.
- R7: In the split-output variant, a selected read with `oe_n` = 1 leaves `dout_en` at 0. In the pass-through variant, `oe_n` has no effect on the outputs.
- R8: After each edge, `pdown` is 1 when `ce1_n` or `ce2_n` was 1 at that edge, and 0 otherwise.
- R9: While `rst_n` is 0 at an edge, the outputs after that edge are `dout_en` = 0, `dout` = 0 and `pdown` = 1.
- R10: Whenever `dout_en` is 0, `dout` is 0.
- R11: A write strobe sampled while either select is 1 does not change the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Word address |
| ce1_n | input | 1 | First chip select, active low |
| ce2_n | input | 1 | Second chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low (split-output variant only) |
| din | input | DATA_W | Word to be written |
| dout | output | DATA_W | Word presented; zero while not driven |
| dout_en | output | 1 | 1 when the emulated output pins would be driven |
| pdown | output | 1 | Power-down status, 1 while deselected |

## Verification
The bench builds two copies at the default `ADDR_W = 11` and `DATA_W = 4`: one with `TRANSPARENT = 0` and one with `TRANSPARENT = 1`, both driven by the same pin sequence. This puts the split-output and pass-through differences side by side on every cycle. The 2048-word array is small enough that the bench can fill every address with a computed pattern and read each one back, which covers the top and bottom addresses. A vector table then runs the boundary cases on both copies:
- reads with the output gate high;
- writes attempted through either select alone;
- a select rising together with the write strobe.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

    // What the most recently sampled edge requested of the emulated RAM.
    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,   // deselected, powered down
        ST_QUIET = 2'd1,   // selected, output gated off
        ST_READ  = 2'd2,   // selected, reading
        ST_WRITE = 2'd3    // selected, writing
    } emu_state_t;

endpackage

// File: rtl/sram_emu_ctrl.sv
module sram_emu_ctrl
    import sram_emu_pkg::*;
#(
    parameter bit TRANSPARENT = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce1_n,
    input  logic       ce2_n,
    input  logic       we_n,
    input  logic       oe_n,
    output logic       wr_en,
    output emu_state_t state_q
);

    logic       deselect;
    logic       gate_open;
    emu_state_t state_d;

    always_comb begin
        deselect  = ce1_n | ce2_n;
        gate_open = TRANSPARENT | ~oe_n;
        wr_en     = ~deselect & ~we_n;
    end

    // Next state is chosen from the sampled pins alone; every state reaches every other.
    always_comb begin
        unique casez ({deselect, we_n, gate_open})
            3'b1??:  state_d = ST_SLEEP;
            3'b00?:  state_d = ST_WRITE;
            3'b011:  state_d = ST_READ;
            3'b010:  state_d = ST_QUIET;
            default: state_d = ST_SLEEP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SLEEP;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/sram_emu_array.sv
module sram_emu_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    // Contents are undefined until written; there is deliberately no reset here.
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[addr] <= din;
        end
        rd_word <= cells[addr];
    end

endmodule

// File: rtl/sram_emu_out.sv
module sram_emu_out
    import sram_emu_pkg::*;
#(
    parameter int DATA_W      = 4,
    parameter bit TRANSPARENT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  emu_state_t        state_q,
    input  logic [DATA_W-1:0] rd_word,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              pdown
);

    logic [DATA_W-1:0] din_q;
    logic              wr_drive;
    logic [DATA_W-1:0] wr_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q <= '0;
        end else begin
            din_q <= din;
        end
    end

    // The variant decides what the pins show while a write is under way.
    generate
        if (TRANSPARENT) begin : g_pass
            assign wr_drive = 1'b1;
            assign wr_word  = din_q;
        end else begin : g_split
            assign wr_drive = 1'b0;
            assign wr_word  = '0;
        end
    endgenerate

    always_comb begin
        unique case (state_q)
            ST_SLEEP: begin
                dout_en = 1'b0;
                dout    = '0;
                pdown   = 1'b1;
            end
            ST_QUIET: begin
                dout_en = 1'b0;
                dout    = '0;
                pdown   = 1'b0;
            end
            ST_READ: begin
                dout_en = 1'b1;
                dout    = rd_word;
                pdown   = 1'b0;
            end
            ST_WRITE: begin
                dout_en = wr_drive;
                dout    = wr_word;
                pdown   = 1'b0;
            end
            default: begin
                dout_en = 1'b0;
                dout    = '0;
                pdown   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sram_emu.sv
module sram_emu
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 4,
    parameter bit TRANSPARENT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              pdown
);

    emu_state_t        state_q;
    logic              wr_en;
    logic [DATA_W-1:0] rd_word;

    sram_emu_ctrl #(
        .TRANSPARENT (TRANSPARENT)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce1_n   (ce1_n),
        .ce2_n   (ce2_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .wr_en   (wr_en),
        .state_q (state_q)
    );

    sram_emu_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .addr    (addr),
        .din     (din),
        .rd_word (rd_word)
    );

    sram_emu_out #(
        .DATA_W      (DATA_W),
        .TRANSPARENT (TRANSPARENT)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_q (state_q),
        .rd_word (rd_word),
        .din     (din),
        .dout    (dout),
        .dout_en (dout_en),
        .pdown   (pdown)
    );

endmodule

// File: rtl/sram_emu_chk.sv
module sram_emu_chk #(
    parameter int DATA_W      = 4,
    parameter bit TRANSPARENT = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce1_n,
    input logic              ce2_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input logic              pdown
);

    // Set once a full cycle out of reset has passed, so $past sees real inputs.
    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R4
    p_desel_float_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(ce1_n | ce2_n) |-> !dout_en);

    // R8
    p_pdown_track_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        pdown == $past(ce1_n | ce2_n));

    // R10
    p_zero_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> dout == '0);

    // R9
    p_reset_state_r9: assert property (@(posedge clk)
        !$past(rst_n) && armed == 1'b0 && $past(armed) == 1'b0 && $past(rst_n) == 1'b0 && rst_n
        |-> !dout_en && pdown);

    generate
        if (TRANSPARENT) begin : g_pass_chk
            // R6
            p_echo_write_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                $past(!ce1_n && !ce2_n && !we_n) |-> dout_en && dout == $past(din));
            // R3, R7
            p_read_drives_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                $past(!ce1_n && !ce2_n && we_n) |-> dout_en);
        end else begin : g_split_chk
            // R5
            p_write_float_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                $past(!we_n) |-> !dout_en);
            // R7
            p_gate_closed_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                $past(oe_n) |-> !dout_en);
            // R3
            p_read_drives_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
                $past(!ce1_n && !ce2_n && we_n && !oe_n) |-> dout_en);
        end
    endgenerate

endmodule

bind sram_emu sram_emu_chk #(
    .DATA_W      (DATA_W),
    .TRANSPARENT (TRANSPARENT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce1_n   (ce1_n),
    .ce2_n   (ce2_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .din     (din),
    .dout    (dout),
    .dout_en (dout_en),
    .pdown   (pdown)
);

// File: tb/sim_sram_emu.sv
module sim_sram_emu;

    localparam int AW    = 11;
    localparam int DW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int NVEC  = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce1_n = 1'b1, ce2_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout0, dout1;
    logic          en0, en1, pd0, pd1;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sram_emu #(.ADDR_W(AW), .DATA_W(DW), .TRANSPARENT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2_n(ce2_n),
        .we_n(we_n), .oe_n(oe_n), .din(din), .dout(dout0), .dout_en(en0), .pdown(pd0));

    sram_emu #(.ADDR_W(AW), .DATA_W(DW), .TRANSPARENT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2_n(ce2_n),
        .we_n(we_n), .oe_n(oe_n), .din(din), .dout(dout1), .dout_en(en1), .pdown(pd1));

    // Row: {ce1_n, ce2_n, we_n, oe_n, addr, din, en_split, dout_split, en_pass, dout_pass}
    function automatic logic [28:0] mk(input logic c1, input logic c2, input logic w, input logic o,
                                       input logic [10:0] a, input logic [3:0] d,
                                       input logic e0, input logic [3:0] q0,
                                       input logic e1, input logic [3:0] q1);
        return {c1, c2, w, o, a, d, e0, q0, e1, q1};
    endfunction

    localparam logic [28:0] VEC [NVEC] = '{
        mk(0,0,0,0, 11'd5,    4'hA, 0,4'h0, 1,4'hA),  // R2 R5 R6 write
        mk(0,0,1,0, 11'd5,    4'h3, 1,4'hA, 1,4'hA),  // R3 read back
        mk(0,0,0,1, 11'd6,    4'hC, 0,4'h0, 1,4'hC),  // R6 write, gate high
        mk(0,0,1,1, 11'd6,    4'h0, 0,4'h0, 1,4'hC),  // R7 gate high read
        mk(0,0,1,0, 11'd6,    4'h0, 1,4'hC, 1,4'hC),  // R3
        mk(1,0,0,0, 11'd6,    4'h7, 0,4'h0, 0,4'h0),  // R11 R4 ce1 high
        mk(0,1,0,0, 11'd6,    4'h7, 0,4'h0, 0,4'h0),  // R11 R4 ce2 high
        mk(0,0,1,0, 11'd6,    4'h0, 1,4'hC, 1,4'hC),  // R11 unchanged
        mk(0,0,0,0, 11'd2047, 4'hF, 0,4'h0, 1,4'hF),  // R1 top address
        mk(0,0,1,0, 11'd2047, 4'h0, 1,4'hF, 1,4'hF),  // R1
        mk(0,0,0,0, 11'd0,    4'h9, 0,4'h0, 1,4'h9),  // write then
        mk(1,1,1,0, 11'd0,    4'h0, 0,4'h0, 0,4'h0),  // R4 select and strobe rise together
        mk(0,0,1,0, 11'd0,    4'h0, 1,4'h9, 1,4'h9)   // R2 stored
    };

    function automatic logic [3:0] pat(input int a);
        logic [10:0] v;
        v = a[10:0];
        return v[3:0] + (v[7:4] ^ {1'b0, v[10:8]});
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic c1, input logic c2, input logic w, input logic o,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        ce1_n = c1; ce2_n = c2; we_n = w; oe_n = o; addr = a; din = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R9 en split", en0, 0);
        check("R9 en pass", en1, 0);
        check("R9 pdown", pd0 & pd1, 1);
        check("R9 R10 dout", {dout0, dout1}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2: fill every word, then read each back
        for (int a = 0; a < DEPTH; a++) begin
            drive(0, 0, 0, 0, AW'(a), pat(a));
            check("R6 echo", {en1, dout1}, {1'b1, pat(a)});
        end
        for (int a = 0; a < DEPTH; a++) begin
            drive(0, 0, 1, 0, AW'(a), 4'h0);
            check("R1 R3 split read", {en0, dout0}, {1'b1, pat(a)});
            check("R1 R3 pass read", {en1, dout1}, {1'b1, pat(a)});
        end

        // Vector table on both variants
        for (int i = 0; i < NVEC; i++) begin
            logic [28:0] v;
            v = VEC[i];
            drive(v[28], v[27], v[26], v[25], v[24:14], v[13:10]);
            check("R3 R5 R7 split en", en0, v[9]);
            check("R3 R10 split dout", dout0, v[8:5]);
            check("R6 R7 pass en", en1, v[4]);
            check("R6 R10 pass dout", dout1, v[3:0]);
            check("R8 pdown split", pd0, v[28] | v[27]);
            check("R8 pdown pass", pd1, v[28] | v[27]);
        end

        // R9: reset while a read is requested
        @(negedge clk);
        rst_n = 1'b0; ce1_n = 0; ce2_n = 0; we_n = 1; oe_n = 0; addr = '0;
        @(posedge clk);
        #1;
        check("R9 mid reset en", {en0, en1}, 0);
        check("R9 mid reset pdown", {pd0, pd1}, 2'b11);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R3 after reset", {en0, dout0}, {1'b1, 4'h9});

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule